// File: doc/BRIEF.md
# Multiplexed Common/Segment Row Scanner

This block produces the refresh sequence for a passive-matrix LCD with sixteen graphic rows plus one icon row. A clock enable at oscillator rate advances a tick counter; each frame of 640 ticks is shared out as time slots, one per active common line. For the slot in progress the block works out which display-RAM row belongs on that common, taking the vertical scroll offset and the row mirroring into account, presents that row number to the display RAM, and turns the 120-bit row word that comes back into a 112-bit segment pattern, mirrored or not.

Alongside the segment pattern it drives a one-hot common select, a one-cycle strobe at the start of every frame and a polarity signal that flips once per frame so the analog drive stage downstream can invert its levels. Setting the display off blanks commons and segments while the slot timing keeps running, so switching it back on resumes at the current point of the frame. The display RAM is outside the block and is read through a combinational row port.

Top module: `lcd_row_scan`

## Requirements
- R1: After a synchronous active-low reset the scan is in slot 0 (com_sel = 1 when the display is on), frame_alt is 0 and frame_strobe is 0.
- R2: A frame lasts exactly 640 ticks in either multiplex mode; on the tick that ends a frame frame_strobe is 1 for the following clock cycle only, and frame_alt toggles at that same edge.
- R3: With mux_full = 1 there are 17 slots: slots 0 to 15 last 37 ticks each and slot 16 lasts 48 ticks. With mux_full = 0 there are 16 slots of 40 ticks each and common 16 is never selected.
- R4: com_sel is one-hot with bit n set during slot n while the display is on; the slot changes only on clock edges where tick is 1.
- R5: For slots 0 to 15 with no row mirroring, ram_row_addr equals (n + scroll) mod 16, where n is the slot number and scroll is the 4-bit offset.
- R6: With row_flip = 1, slot n (0 to 15) reads RAM row ((15 - n) + scroll) mod 16.
- R7: Slot 16 always reads RAM row 16 (the icon row, ram_row_addr = 16), whatever scroll and row_flip are.
- R8: With col_flip = 0, seg_out bit k equals ram_row_data bit k for k = 0 to 111; with col_flip = 1, seg_out bit k equals ram_row_data bit 119 - k.
- R9: With disp_on = 0, com_sel and seg_out are all zero while slot timing, frame_alt and frame_strobe keep advancing; after disp_on returns to 1 the select shows the slot reached meanwhile.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tick | input | 1 | Oscillator-rate clock enable, one tick per cycle it is high |
| disp_on | input | 1 | 1 drives commons and segments, 0 blanks them |
| mux_full | input | 1 | 1 selects 17 commons (icon row scanned), 0 selects 16 |
| scroll | input | 4 | Vertical scroll offset applied to rows 0 to 15 |
| row_flip | input | 1 | 1 mirrors the common order of rows 0 to 15 |
| col_flip | input | 1 | 1 maps columns 119 down to 8 onto segments 0 to 111 |
| ram_row_data | input | 120 | Row word returned by the display RAM for ram_row_addr, bit = column |
| ram_row_addr | output | 5 | RAM row read for the current slot, 16 = icon row |
| com_sel | output | 17 | One-hot common select, bit n = common n |
| seg_out | output | 112 | Segment pattern for the current slot, bit k = segment k |
| frame_alt | output | 1 | Drive polarity, toggles once per frame |
| frame_strobe | output | 1 | One-cycle pulse at the start of each frame |

## Verification
The row mapping is tried with a spread of scroll values, both row orientations and both column orientations in both multiplex modes, and a RAM model whose rows all differ and are not mirror-symmetric, so a wrong row, a missing modulo wrap or a reversed column order each shows in a different way. Slot and frame timing are probed one tick before and one tick after each boundary of the short and long last slot, which separates an off-by-one slot length from a wrong remainder placement. Blanking is tried while ticks keep arriving, which distinguishes frozen timing from mere output gating.

// File: rtl/lcd_scan_pkg.sv
// Package: shared dimensions of the row scanner.
// Assumes: one graphic area of SCAN_ROWS rows plus one icon row.
package lcd_scan_pkg;
    localparam int SCAN_ROWS  = 16;   // graphic rows subject to scroll/remap
    localparam int SCAN_COLS  = 120;  // columns in one RAM row word
    localparam int SCAN_SEGS  = 112;  // segment drivers
    localparam int SCAN_FRAME = 640;  // ticks per frame

    // Number of bits needed to hold values 0..n-1 (at least 1).
    function automatic int bits_for(input int n);
        return (n <= 2) ? 1 : $clog2(n);
    endfunction
endpackage

// File: rtl/lcd_slot_timer.sv
// Module: lcd_slot_timer
// Divides a frame of FRAME_TICKS oscillator ticks into equal common slots,
// the remainder going to the last slot. Produces the slot index, a frame
// start strobe and a per-frame polarity bit.
// Assumes: tick is a single-cycle enable; mux_full may change at any time,
// an out-of-range slot is then closed at its next boundary.
module lcd_slot_timer
    import lcd_scan_pkg::*;
#(
    parameter int ROWS        = SCAN_ROWS,
    parameter int FRAME_TICKS = SCAN_FRAME,
    localparam int COMS       = ROWS + 1,
    localparam int SLOT_W     = bits_for(COMS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              mux_full,
    output logic [SLOT_W-1:0] slot,
    output logic              frame_strobe,
    output logic              frame_alt
);
    localparam int CNT_W   = bits_for(FRAME_TICKS);
    localparam int BASE_F  = FRAME_TICKS / COMS;
    localparam int LAST_F  = FRAME_TICKS - ROWS * BASE_F;
    localparam int BASE_S  = FRAME_TICKS / ROWS;
    localparam int LAST_S  = FRAME_TICKS - (ROWS - 1) * BASE_S;
    localparam int MAX_F   = (LAST_F > BASE_F) ? LAST_F : BASE_F;
    localparam int MAX_S   = (LAST_S > BASE_S) ? LAST_S : BASE_S;
    localparam int MAX_LEN = (MAX_F > MAX_S) ? MAX_F : MAX_S;

    localparam logic [CNT_W-1:0]  BASE_F_M1 = CNT_W'(BASE_F - 1);
    localparam logic [CNT_W-1:0]  LAST_F_M1 = CNT_W'(LAST_F - 1);
    localparam logic [CNT_W-1:0]  BASE_S_M1 = CNT_W'(BASE_S - 1);
    localparam logic [CNT_W-1:0]  LAST_S_M1 = CNT_W'(LAST_S - 1);
    localparam logic [CNT_W-1:0]  MAX_M1    = CNT_W'(MAX_LEN - 1);
    localparam logic [SLOT_W-1:0] END_F     = SLOT_W'(ROWS);
    localparam logic [SLOT_W-1:0] END_S     = SLOT_W'(ROWS - 1);

    logic [CNT_W-1:0]  cnt_q;
    logic [SLOT_W-1:0] slot_q;
    logic              alt_q;
    logic              strobe_q;
    logic              last_slot;
    logic [CNT_W-1:0]  cnt_lim;
    logic              at_edge;

    // Decide whether the current slot is the final one of the frame.
    always_comb begin
        last_slot = mux_full ? (slot_q >= END_F) : (slot_q >= END_S);
    end

    // Pick the terminal count of the current slot.
    always_comb begin
        if (last_slot) cnt_lim = mux_full ? LAST_F_M1 : LAST_S_M1;
        else           cnt_lim = mux_full ? BASE_F_M1 : BASE_S_M1;
        at_edge = (cnt_q >= cnt_lim);
    end

    // Advance tick count, slot index, polarity and frame strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q    <= '0;
            slot_q   <= '0;
            alt_q    <= 1'b0;
            strobe_q <= 1'b0;
        end else begin
            strobe_q <= 1'b0;
            if (tick) begin
                if (at_edge) begin
                    cnt_q <= '0;
                    if (last_slot) begin
                        slot_q   <= '0;
                        alt_q    <= ~alt_q;
                        strobe_q <= 1'b1;
                    end else begin
                        slot_q <= slot_q + 1'b1;
                    end
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end

    assign slot         = slot_q;
    assign frame_strobe = strobe_q;
    assign frame_alt    = alt_q;

    // R4
    slot_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(slot_q));
    // R2
    strobe_alt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_q |-> (alt_q != $past(alt_q)));
    // R2
    strobe_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_q |-> (slot_q == '0 && cnt_q == '0));
    // R3
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= MAX_M1);
endmodule

// File: rtl/lcd_row_map.sv
// Module: lcd_row_map
// Translates a common slot into the RAM row shown on it: graphic slots are
// optionally mirrored, then rotated by the scroll offset modulo ROWS; the
// icon slot always reads row ROWS.
// Assumes: purely combinational; scroll < ROWS.
module lcd_row_map
    import lcd_scan_pkg::*;
#(
    parameter int ROWS    = SCAN_ROWS,
    localparam int SLOT_W = bits_for(ROWS + 1),
    localparam int SCR_W  = bits_for(ROWS)
) (
    input  logic [SLOT_W-1:0] slot,
    input  logic [SCR_W-1:0]  scroll,
    input  logic              row_flip,
    output logic [SLOT_W-1:0] row_addr
);
    localparam logic [SLOT_W-1:0] ICON_ROW = SLOT_W'(ROWS);
    localparam logic [SLOT_W:0]   TOP      = (SLOT_W+1)'(ROWS - 1);
    localparam logic [SLOT_W:0]   MODULUS  = (SLOT_W+1)'(ROWS);

    logic [SLOT_W:0] line;
    logic [SLOT_W:0] sum;
    logic [SLOT_W:0] wrapped;

    // Mirror the slot when row remapping is selected.
    always_comb begin
        line = row_flip ? (TOP - {1'b0, slot}) : {1'b0, slot};
    end

    // Rotate by the scroll offset, wrapping within the graphic rows.
    always_comb begin
        sum     = line + (SLOT_W+1)'(scroll);
        wrapped = (sum >= MODULUS) ? (sum - MODULUS) : sum;
    end

    // Icon slot bypasses both mirroring and scroll.
    always_comb begin
        if (slot >= ICON_ROW) row_addr = ICON_ROW;
        else                  row_addr = wrapped[SLOT_W-1:0];
    end
endmodule

// File: rtl/lcd_col_map.sv
// Module: lcd_col_map
// Selects SEGS columns of a RAM row word onto the segment drivers, either
// straight (column k to segment k) or mirrored from the top column down.
// Assumes: COLS >= SEGS; purely combinational.
module lcd_col_map
    import lcd_scan_pkg::*;
#(
    parameter int COLS = SCAN_COLS,
    parameter int SEGS = SCAN_SEGS
) (
    input  logic [COLS-1:0] row_data,
    input  logic            col_flip,
    output logic [SEGS-1:0] seg
);
    // One selector per segment, choosing its straight or mirrored column.
    for (genvar k = 0; k < SEGS; k++) begin : g_seg
        assign seg[k] = col_flip ? row_data[COLS-1-k] : row_data[k];
    end

    if (COLS > SEGS) begin : g_spare
        // Columns SEGS..COLS-SEGS-1 are never driven in either orientation
        // when COLS exceeds 2*SEGS; none exist at the default size.
    end
endmodule

// File: rtl/lcd_row_scan.sv
// Module: lcd_row_scan (top)
// Refresh sequencer for a multiplexed LCD: slot timing, row selection with
// scroll and remap, segment fetch with column remap, and output blanking.
// Assumes: the display RAM answers ram_row_addr combinationally on
// ram_row_data; all configuration inputs are synchronous to clk.
module lcd_row_scan
    import lcd_scan_pkg::*;
#(
    parameter int ROWS        = SCAN_ROWS,
    parameter int COLS        = SCAN_COLS,
    parameter int SEGS        = SCAN_SEGS,
    parameter int FRAME_TICKS = SCAN_FRAME,
    localparam int COMS       = ROWS + 1,
    localparam int SLOT_W     = bits_for(COMS),
    localparam int SCR_W      = bits_for(ROWS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              disp_on,
    input  logic              mux_full,
    input  logic [SCR_W-1:0]  scroll,
    input  logic              row_flip,
    input  logic              col_flip,
    input  logic [COLS-1:0]   ram_row_data,
    output logic [SLOT_W-1:0] ram_row_addr,
    output logic [COMS-1:0]   com_sel,
    output logic [SEGS-1:0]   seg_out,
    output logic              frame_alt,
    output logic              frame_strobe
);
    logic [SLOT_W-1:0] slot;
    logic [SEGS-1:0]   seg_raw;

    lcd_slot_timer #(
        .ROWS        (ROWS),
        .FRAME_TICKS (FRAME_TICKS)
    ) i_timer (
        .clk          (clk),
        .rst_n        (rst_n),
        .tick         (tick),
        .mux_full     (mux_full),
        .slot         (slot),
        .frame_strobe (frame_strobe),
        .frame_alt    (frame_alt)
    );

    lcd_row_map #(
        .ROWS (ROWS)
    ) i_rows (
        .slot     (slot),
        .scroll   (scroll),
        .row_flip (row_flip),
        .row_addr (ram_row_addr)
    );

    lcd_col_map #(
        .COLS (COLS),
        .SEGS (SEGS)
    ) i_cols (
        .row_data (ram_row_data),
        .col_flip (col_flip),
        .seg      (seg_raw)
    );

    // Decode the slot into one common line, blanked while the display is off.
    for (genvar n = 0; n < COMS; n++) begin : g_com
        assign com_sel[n] = disp_on && (slot == SLOT_W'(n));
    end

    // Gate the segment pattern to the inactive level while the display is off.
    always_comb begin
        seg_out = disp_on ? seg_raw : '0;
    end

    // R4
    onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(com_sel));
    // R9
    blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !disp_on |-> (com_sel == '0 && seg_out == '0));
    // R7
    icon_row_chk: assert property (@(posedge clk) disable iff (!rst_n)
        com_sel[ROWS] |-> (ram_row_addr == SLOT_W'(ROWS)));
    // R3
    short_mux_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mux_full && $past(!mux_full) && $past(!com_sel[ROWS])) |-> !com_sel[ROWS]);
endmodule

// File: tb/test_lcd_row_scan.sv
module test_lcd_row_scan;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         tick = 1'b0;
    logic         disp_on = 1'b1;
    logic         mux_full = 1'b1;
    logic [3:0]   scroll = 4'd0;
    logic         row_flip = 1'b0;
    logic         col_flip = 1'b0;
    logic [119:0] ram_row_data;
    logic [4:0]   ram_row_addr;
    logic [16:0]  com_sel;
    logic [111:0] seg_out;
    logic         frame_alt;
    logic         frame_strobe;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    lcd_row_scan i_lcd_row_scan (
        .clk          (clk),
        .rst_n        (rst_n),
        .tick         (tick),
        .disp_on      (disp_on),
        .mux_full     (mux_full),
        .scroll       (scroll),
        .row_flip     (row_flip),
        .col_flip     (col_flip),
        .ram_row_data (ram_row_data),
        .ram_row_addr (ram_row_addr),
        .com_sel      (com_sel),
        .seg_out      (seg_out),
        .frame_alt    (frame_alt),
        .frame_strobe (frame_strobe)
    );

    // RAM model: every row distinct and not mirror-symmetric.
    function automatic logic [119:0] ram_word(input int r);
        logic [119:0] w;
        for (int j = 0; j < 120; j++) w[j] = ((j + 3 * r) % 7 == 0) || (j == r * 5);
        return w;
    endfunction

    function automatic logic [111:0] exp_seg(input int r, input logic fl);
        logic [119:0] w = ram_word(r);
        logic [111:0] s;
        for (int k = 0; k < 112; k++) s[k] = fl ? w[119 - k] : w[k];
        return s;
    endfunction

    always_comb ram_row_data = ram_word(int'(ram_row_addr));

    task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        tick  = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic run_ticks(input int k);
        if (k > 0) begin
            tick = 1'b1;
            repeat (k) @(negedge clk);
            tick = 1'b0;
        end
        #1;
    endtask

    // mux_full, scroll, row_flip, col_flip, slot, expected RAM row
    localparam int VEC [0:9][0:5] = '{
        '{0,  0, 0, 0,  0,  0},
        '{0,  0, 0, 0,  5,  5},
        '{0,  1, 0, 0, 15,  0},
        '{0,  3, 0, 1, 14,  1},
        '{0,  0, 1, 0,  0, 15},
        '{0,  2, 1, 1, 15,  2},
        '{1,  5, 0, 0, 16, 16},
        '{1,  7, 1, 0, 16, 16},
        '{1, 15, 0, 1,  3,  2},
        '{1,  9, 1, 1, 10, 14}
    };

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        // R1 reset state
        do_reset();
        #1;
        check("R1 com_sel", 128'(com_sel), 128'(17'd1));
        check("R1 frame_alt", 128'(frame_alt), 128'(0));
        check("R1 frame_strobe", 128'(frame_strobe), 128'(0));

        // Table: R5 R6 R7 R8 mapping across configurations
        for (int v = 0; v < 10; v++) begin
            mux_full = VEC[v][0][0];
            scroll   = 4'(VEC[v][1]);
            row_flip = VEC[v][2][0];
            col_flip = VEC[v][3][0];
            do_reset();
            run_ticks(VEC[v][4] * (VEC[v][0] != 0 ? 37 : 40));
            check("R4 table com_sel", 128'(com_sel), 128'(17'd1 << VEC[v][4]));
            check("R5/R6/R7 table row", 128'(ram_row_addr), 128'(VEC[v][5]));
            check("R8 table seg", 128'(seg_out), 128'(exp_seg(VEC[v][5], col_flip)));
        end

        // R3 R2: 17-slot frame boundaries
        mux_full = 1'b1; scroll = 4'd0; row_flip = 1'b0; col_flip = 1'b0;
        do_reset();
        run_ticks(591);
        check("R3 slot15 before 592", 128'(com_sel), 128'(17'd1 << 15));
        run_ticks(1);
        check("R3 slot16 at 592", 128'(com_sel), 128'(17'd1 << 16));
        run_ticks(47);
        check("R3 slot16 at 639", 128'(com_sel), 128'(17'd1 << 16));
        check("R2 no strobe at 639", 128'(frame_strobe), 128'(0));
        run_ticks(1);
        check("R2 strobe at 640", 128'(frame_strobe), 128'(1));
        check("R2 alt toggled", 128'(frame_alt), 128'(1));
        check("R2 wrap slot0", 128'(com_sel), 128'(17'd1));
        @(negedge clk); #1;
        check("R2 strobe one cycle", 128'(frame_strobe), 128'(0));
        // R4 hold without ticks
        repeat (5) @(negedge clk);
        #1;
        check("R4 hold without tick", 128'(com_sel), 128'(17'd1));

        // R3 R2: 16-slot frame
        mux_full = 1'b0;
        do_reset();
        run_ticks(39);
        check("R3 mux16 slot0 at 39", 128'(com_sel), 128'(17'd1));
        run_ticks(1);
        check("R3 mux16 slot1 at 40", 128'(com_sel), 128'(17'd1 << 1));
        run_ticks(599);
        check("R3 mux16 slot15 at 639", 128'(com_sel), 128'(17'd1 << 15));
        check("R2 mux16 no strobe", 128'(frame_strobe), 128'(0));
        run_ticks(1);
        check("R2 mux16 strobe", 128'(frame_strobe), 128'(1));
        check("R3 mux16 wrap slot0", 128'(com_sel), 128'(17'd1));
        run_ticks(640);
        check("R2 alt second frame", 128'(frame_alt), 128'(0));

        // R9 blanking with timing running
        disp_on = 1'b0;
        #1;
        check("R9 com blank", 128'(com_sel), 128'(0));
        check("R9 seg blank", 128'(seg_out), 128'(0));
        run_ticks(80);
        check("R9 com blank after ticks", 128'(com_sel), 128'(0));
        check("R9 seg blank after ticks", 128'(seg_out), 128'(0));
        disp_on = 1'b1;
        #1;
        check("R9 resume slot2", 128'(com_sel), 128'(17'd1 << 2));
        check("R9 resume seg", 128'(seg_out), 128'(exp_seg(2, 1'b0)));

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule